// File: doc/BRIEF.md
# Memory Access Range Protection Monitor

This block sits beside a memory controller and watches every transaction offered on an observation port. Each transaction carries an address, a direction (read or write), a requester port number and a sub-port number. The block compares the transaction against two programmable protected spans. Each span is set in 64 KB units and has its own allow mask, indexed by requester port. A transaction that lands inside a span, comes from a port that span does not allow, and has a direction that span checks is a violation.

Reads and writes are tracked apart. Each direction has a sticky flag, an address capture register and an information capture register. The first violation in a direction is held in that direction's capture registers until software clears the flag. The interrupt line is high while either flag is set. Software uses a simple word-addressed register port to program the spans, read the captures and clear the flags. It clears a flag by writing 1 to it.

Top module: `mem_guard_mon`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The span words sit at word offsets 0xA0 (span 0) and 0xA2 (span 1). Each holds the start unit in bits [15:0] and the end unit in bits [31:16], and reads back all 32 bits. The control words sit at 0xA1 and 0xA3. Each keeps only its port allow mask in bits [23:0], the write-check enable in bit 24, a stored mode bit in bit 25 and the read-check enable in bit 26. All other control bits read as 0.
- R3: An address hits a span when address[31:16] is at least the start unit and at most the end unit, both ends inclusive.
- R4: A transaction from port p is a violation of a span when all of these hold: it hits the span, allow bit p of the span is 0, and the span checks that direction. Ports 24 to 31 have no allow bit and are never allowed. Bit 25 has no effect on checking. Both span words at 0 disable a span.
- R5: In the status word at 0xB8, bit 0 is the read-violation flag and bit 1 is the write-violation flag. A flag is set on the clock edge that samples a violating transaction with `obs_valid` high.
- R6: A captured violation stores the full address and an info word. The write pair is at 0xB9 (address) and 0xBA (info); the read pair is at 0xBB (address) and 0xBC (info). The info word holds the sub-port in bits [9:6], the port in bits [14:10], and bit 21 / bit 22 for span 0 / span 1. Both span bits are set when both spans are violated. All other info bits are 0.
- R7: While a direction's flag is set and not being cleared, later violations in that direction leave its capture registers unchanged.
- R8: Writing to 0xB8 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If a clear and a new violation in the same direction fall on the same edge, the flag stays set and the new violation is captured.
- R9: `irq` is high exactly when at least one flag is set.
- R10: Writes to the capture registers and to unmapped offsets have no effect, and unmapped offsets read as 0.
- R11: A transaction with `obs_valid` low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | Observed transaction is present this cycle |
| obs_write | input | 1 | 1 = write, 0 = read |
| obs_addr | input | 32 | Transaction byte address |
| obs_port | input | 5 | Requester port number |
| obs_sub | input | 4 | Requester sub-port number |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| irq | output | 1 | Violation interrupt |

## Verification
The hardest case to reach is a clear of a flag and a new violation in the same direction on the same clock edge. The flag must stay set, and the captures must take the new violation rather than keep the stale one. The bench gets there by driving the status write and a violating beat in the same low clock phase. It also sweeps unit indices across both span edges, all 32 ports and both directions while clearing at irregular intervals. That sweep walks the captures through the held, freshly cleared and overlapping-span cases against a model of its own.

// File: rtl/mgm_pkg.sv
`timescale 1ns/1ps
package mgm_pkg;
  // register word offsets
  localparam logic [7:0] OFS_SPAN_BASE = 8'hA0;
  localparam logic [7:0] OFS_STATUS    = 8'hB8;
  localparam logic [7:0] OFS_WR_ADDR   = 8'hB9;
  localparam logic [7:0] OFS_WR_INFO   = 8'hBA;
  localparam logic [7:0] OFS_RD_ADDR   = 8'hBB;
  localparam logic [7:0] OFS_RD_INFO   = 8'hBC;

  // control word bit positions
  localparam int CTL_WEN_BIT  = 24;
  localparam int CTL_MODE_BIT = 25;
  localparam int CTL_REN_BIT  = 26;

  // info word field positions
  localparam int INFO_SUB_LSB  = 6;
  localparam int INFO_PORT_LSB = 10;
  localparam int INFO_HIT_LSB  = 21;

  // direction index, equal to the status bit position
  typedef enum int {DIR_RD = 0, DIR_WR = 1} dir_e;

  // inclusive span test on 64 KB unit indices
  function automatic logic span_hit(input logic [31:0] unit_idx,
                                    input logic [15:0] lo,
                                    input logic [15:0] hi);
    return (unit_idx >= {16'd0, lo}) && (unit_idx <= {16'd0, hi});
  endfunction

  // offsets of span r's two words
  function automatic logic [7:0] span_ofs(input int r);
    return OFS_SPAN_BASE + 8'(2 * r);
  endfunction

  function automatic logic [7:0] ctl_ofs(input int r);
    return OFS_SPAN_BASE + 8'(2 * r + 1);
  endfunction
endpackage

// File: rtl/mgm_range_chk.sv
`timescale 1ns/1ps
module mgm_range_chk
  import mgm_pkg::*;
#(
  parameter int MASK_W = 24,
  parameter int PORT_W = 5
) (
  input  logic              obs_valid,
  input  logic              obs_write,
  input  logic [31:0]       unit_idx,
  input  logic [PORT_W-1:0] obs_port,
  input  logic [15:0]       lo,
  input  logic [15:0]       hi,
  input  logic [MASK_W-1:0] mask,
  input  logic              wen,
  input  logic              ren,
  output logic              viol
);
  logic in_span;
  logic port_ok;
  logic dir_on;

  assign in_span = span_hit(unit_idx, lo, hi);
  // ports beyond the mask width shift out to zero: never allowed
  assign port_ok = |(mask & (MASK_W'(1) << obs_port));
  assign dir_on  = obs_write ? wen : ren;
  assign viol    = obs_valid && in_span && !port_ok && dir_on;
endmodule

// File: rtl/mgm_capture.sv
`timescale 1ns/1ps
module mgm_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       info,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [31:0]       cap_info
);
  logic held;
  logic take;

  assign held = flag && !clr;
  assign take = hit && !held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      cap_addr <= '0;
      cap_info <= '0;
    end else begin
      flag <= held || hit;
      if (take) begin
        cap_addr <= addr;
        cap_info <= info;
      end
    end
  end
endmodule

// File: rtl/mgm_regs.sv
`timescale 1ns/1ps
module mgm_regs
  import mgm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MASK_W     = 24,
  parameter int NUM_RANGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_wr,
  input  logic [7:0]                         cfg_addr,
  input  logic [31:0]                        cfg_wdata,
  input  logic [1:0]                         sts,
  input  logic [ADDR_W-1:0]                  cap_addr [2],
  input  logic [31:0]                        cap_info [2],
  output logic [NUM_RANGES-1:0][15:0]        rng_lo,
  output logic [NUM_RANGES-1:0][15:0]        rng_hi,
  output logic [NUM_RANGES-1:0][MASK_W-1:0]  rng_mask,
  output logic [NUM_RANGES-1:0]              rng_wen,
  output logic [NUM_RANGES-1:0]              rng_ren,
  output logic [1:0]                         sts_clr,
  output logic [31:0]                        cfg_rdata
);
  logic [NUM_RANGES-1:0] rng_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng_lo   <= '0;
      rng_hi   <= '0;
      rng_mask <= '0;
      rng_wen  <= '0;
      rng_ren  <= '0;
      rng_mode <= '0;
    end else if (cfg_wr) begin
      for (int r = 0; r < NUM_RANGES; r++) begin
        if (cfg_addr == span_ofs(r)) begin
          rng_lo[r] <= cfg_wdata[15:0];
          rng_hi[r] <= cfg_wdata[31:16];
        end
        if (cfg_addr == ctl_ofs(r)) begin
          rng_mask[r] <= cfg_wdata[MASK_W-1:0];
          rng_wen[r]  <= cfg_wdata[CTL_WEN_BIT];
          rng_mode[r] <= cfg_wdata[CTL_MODE_BIT];
          rng_ren[r]  <= cfg_wdata[CTL_REN_BIT];
        end
      end
    end
  end

  assign sts_clr = (cfg_wr && cfg_addr == OFS_STATUS) ? cfg_wdata[1:0] : 2'b00;

  always_comb begin
    cfg_rdata = '0;
    for (int r = 0; r < NUM_RANGES; r++) begin
      if (cfg_addr == span_ofs(r)) cfg_rdata = {rng_hi[r], rng_lo[r]};
      if (cfg_addr == ctl_ofs(r)) begin
        cfg_rdata[MASK_W-1:0]   = rng_mask[r];
        cfg_rdata[CTL_WEN_BIT]  = rng_wen[r];
        cfg_rdata[CTL_MODE_BIT] = rng_mode[r];
        cfg_rdata[CTL_REN_BIT]  = rng_ren[r];
      end
    end
    case (cfg_addr)
      OFS_STATUS:  cfg_rdata = {30'd0, sts};
      OFS_WR_ADDR: cfg_rdata = 32'(cap_addr[DIR_WR]);
      OFS_WR_INFO: cfg_rdata = cap_info[DIR_WR];
      OFS_RD_ADDR: cfg_rdata = 32'(cap_addr[DIR_RD]);
      OFS_RD_INFO: cfg_rdata = cap_info[DIR_RD];
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_guard_mon.sv
`timescale 1ns/1ps
module mem_guard_mon
  import mgm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MASK_W     = 24,
  parameter int PORT_W     = 5,
  parameter int SUB_W      = 4,
  parameter int UNIT_SHIFT = 16,
  parameter int NUM_RANGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic              obs_write,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [PORT_W-1:0] obs_port,
  input  logic [SUB_W-1:0]  obs_sub,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq
);
  localparam int NUM_DIRS = 2;

  logic [NUM_RANGES-1:0][15:0]       rng_lo;
  logic [NUM_RANGES-1:0][15:0]       rng_hi;
  logic [NUM_RANGES-1:0][MASK_W-1:0] rng_mask;
  logic [NUM_RANGES-1:0]             rng_wen;
  logic [NUM_RANGES-1:0]             rng_ren;
  logic [NUM_RANGES-1:0]             rng_viol;
  logic [31:0]                       unit_idx;
  logic                              viol_any;
  logic                              viol_rd;
  logic                              viol_wr;
  logic [NUM_DIRS-1:0]               dir_viol;
  logic [NUM_DIRS-1:0]               sts;
  logic [NUM_DIRS-1:0]               sts_clr;
  logic [ADDR_W-1:0]                 cap_addr [NUM_DIRS];
  logic [31:0]                       cap_info [NUM_DIRS];
  logic [31:0]                       info_word;

  function automatic logic [31:0] pack_info(input logic [PORT_W-1:0]     p,
                                            input logic [SUB_W-1:0]      s,
                                            input logic [NUM_RANGES-1:0] h);
    logic [31:0] w;
    w = '0;
    w[INFO_SUB_LSB  +: SUB_W]      = s;
    w[INFO_PORT_LSB +: PORT_W]     = p;
    w[INFO_HIT_LSB  +: NUM_RANGES] = h;
    return w;
  endfunction

  assign unit_idx = 32'(obs_addr >> UNIT_SHIFT);

  mgm_regs #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .NUM_RANGES(NUM_RANGES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sts(sts), .cap_addr(cap_addr), .cap_info(cap_info),
    .rng_lo(rng_lo), .rng_hi(rng_hi), .rng_mask(rng_mask),
    .rng_wen(rng_wen), .rng_ren(rng_ren), .sts_clr(sts_clr),
    .cfg_rdata(cfg_rdata)
  );

  for (genvar r = 0; r < NUM_RANGES; r++) begin : g_span
    mgm_range_chk #(.MASK_W(MASK_W), .PORT_W(PORT_W)) u_chk (
      .obs_valid(obs_valid), .obs_write(obs_write), .unit_idx(unit_idx),
      .obs_port(obs_port), .lo(rng_lo[r]), .hi(rng_hi[r]),
      .mask(rng_mask[r]), .wen(rng_wen[r]), .ren(rng_ren[r]),
      .viol(rng_viol[r])
    );
  end

  assign viol_any  = |rng_viol;
  assign viol_rd   = viol_any && !obs_write;
  assign viol_wr   = viol_any && obs_write;
  assign dir_viol  = {viol_wr, viol_rd};
  assign info_word = pack_info(obs_port, obs_sub, rng_viol);

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    mgm_capture #(.ADDR_W(ADDR_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .hit(dir_viol[d]), .clr(sts_clr[d]),
      .addr(obs_addr), .info(info_word), .flag(sts[d]),
      .cap_addr(cap_addr[d]), .cap_info(cap_info[d])
    );
  end

  assign irq = |sts;
endmodule

// File: rtl/mgm_checker.sv
`timescale 1ns/1ps
module mgm_checker #(
  parameter int ADDR_W     = 32,
  parameter int NUM_RANGES = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  obs_valid,
  input logic                  irq,
  input logic                  viol_rd,
  input logic                  viol_wr,
  input logic [1:0]            sts,
  input logic [1:0]            sts_clr,
  input logic [NUM_RANGES-1:0] rng_ren,
  input logic [NUM_RANGES-1:0] rng_wen,
  input logic [ADDR_W-1:0]     rd_addr,
  input logic [31:0]           rd_info,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [31:0]           wr_info
);
  AST_RD_VIOL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rd |=> sts[0]); // R5
  AST_WR_VIOL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_wr |=> sts[1]); // R5
  AST_RD_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(viol_rd)); // R5
  AST_WR_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> $past(viol_wr)); // R5
  AST_RD_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[0] && !sts_clr[0]) |=> ($stable(rd_addr) && $stable(rd_info))); // R7
  AST_WR_CAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sts[1] && !sts_clr[1]) |=> ($stable(wr_addr) && $stable(wr_info))); // R7
  AST_RD_INFO_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    sts[0] |-> (|rd_info[21 +: NUM_RANGES])); // R6
  AST_WR_INFO_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    sts[1] |-> (|wr_info[21 +: NUM_RANGES])); // R6
  AST_IRQ_DROP_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|sts_clr)); // R8
  AST_VIOL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_rd || viol_wr) |-> obs_valid); // R11
  AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rd |-> (|rng_ren)); // R4
  AST_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    viol_wr |-> (|rng_wen)); // R4
endmodule

bind mem_guard_mon mgm_checker #(.ADDR_W(ADDR_W), .NUM_RANGES(NUM_RANGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .irq(irq),
  .viol_rd(viol_rd), .viol_wr(viol_wr), .sts(sts), .sts_clr(sts_clr),
  .rng_ren(rng_ren), .rng_wen(rng_wen),
  .rd_addr(cap_addr[0]), .rd_info(cap_info[0]),
  .wr_addr(cap_addr[1]), .wr_info(cap_info[1])
);

// File: tb/sim_mem_guard_mon.sv
`timescale 1ns/1ps
module sim_mem_guard_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obs_valid = 1'b0, obs_write = 1'b0;
  logic [31:0] obs_addr = '0;
  logic [4:0]  obs_port = '0;
  logic [3:0]  obs_sub = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  mem_guard_mon u0 (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_write(obs_write),
    .obs_addr(obs_addr), .obs_port(obs_port), .obs_sub(obs_sub),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model: spans, controls, flags, captures (wr addr, wr info, rd addr, rd info)
  logic [31:0] m_span [2];
  logic [31:0] m_ctl  [2];
  logic [1:0]  m_sts;
  logic [31:0] m_cap  [4];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  function automatic void model_cfg(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'hA0: m_span[0] = d;
      8'hA2: m_span[1] = d;
      8'hA1: m_ctl[0] = d & 32'h07FF_FFFF;
      8'hA3: m_ctl[1] = d & 32'h07FF_FFFF;
      8'hB8: m_sts = m_sts & ~d[1:0];
      default: ;
    endcase
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    model_cfg(a, d);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  function automatic logic [1:0] m_hits(input logic [31:0] a, input logic [4:0] p, input logic w);
    logic [1:0] h;
    for (int r = 0; r < 2; r++) begin
      int u = int'(a >> 16);
      bit inside_span = (u >= int'(m_span[r][15:0])) && (u <= int'(m_span[r][31:16]));
      bit allowed = (p < 24) && m_ctl[r][p];
      bit en = w ? m_ctl[r][24] : m_ctl[r][26];
      h[r] = inside_span && !allowed && en;
    end
    return h;
  endfunction

  // one observed beat, optionally with a status clear in the same cycle
  task automatic beat(input logic [31:0] a, input logic [4:0] p, input logic [3:0] s,
                      input logic w, input logic v, input logic [1:0] clr);
    logic [1:0] h;
    int d;
    @(negedge clk);
    obs_addr = a; obs_port = p; obs_sub = s; obs_write = w; obs_valid = v;
    if (clr != 0) begin cfg_wr = 1; cfg_addr = 8'hB8; cfg_wdata = {30'd0, clr}; end
    h = v ? m_hits(a, p, w) : 2'b00;
    d = w ? 1 : 0;
    m_sts = m_sts & ~clr;
    if (h != 0) begin
      if (!m_sts[d]) begin
        m_cap[w ? 0 : 2] = a;
        m_cap[w ? 1 : 3] = (32'(s) << 6) | (32'(p) << 10) | (32'(h) << 21);
      end
      m_sts[d] = 1'b1;
    end
    @(negedge clk);
    obs_valid = 0; cfg_wr = 0;
  endtask

  task automatic check_state(input string ctx);
    logic [31:0] v;
    check({ctx, " R9 irq"}, {31'd0, irq}, {31'd0, |m_sts});
    rd_reg(8'hB8, v); check({ctx, " R5 status"}, v, {30'd0, m_sts});
    rd_reg(8'hB9, v); check({ctx, " R6 wr addr"}, v, m_cap[0]);
    rd_reg(8'hBA, v); check({ctx, " R6 wr info"}, v, m_cap[1]);
    rd_reg(8'hBB, v); check({ctx, " R6 rd addr"}, v, m_cap[2]);
    rd_reg(8'hBC, v); check({ctx, " R6 rd info"}, v, m_cap[3]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k;
    for (int i = 0; i < 2; i++) begin m_span[i] = 0; m_ctl[i] = 0; end
    for (int i = 0; i < 4; i++) m_cap[i] = 0;
    m_sts = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    for (int a = 8'hA0; a <= 8'hA3; a++) begin
      rd_reg(8'(a), v); check("R1 span/ctl reset", v, 32'd0);
    end
    check_state("R1 reset");

    // R2: readback of span and control words
    wr_reg(8'hA1, 32'hFFFF_FFFF); rd_reg(8'hA1, v); check("R2 ctl0 readback", v, 32'h07FF_FFFF);
    wr_reg(8'hA3, 32'hFA5A_A5A5); rd_reg(8'hA3, v); check("R2 ctl1 readback", v, 32'h025A_A5A5);
    wr_reg(8'hA0, 32'h1234_ABCD); rd_reg(8'hA0, v); check("R2 span0 readback", v, 32'h1234_ABCD);
    wr_reg(8'hA2, 32'hFFFF_0001); rd_reg(8'hA2, v); check("R2 span1 readback", v, 32'hFFFF_0001);

    // R10: capture registers read-only, unmapped ignored
    wr_reg(8'hB9, 32'hDEAD_BEEF); wr_reg(8'hBC, 32'h1111_2222); wr_reg(8'h10, 32'h5555_5555);
    rd_reg(8'h10, v); check("R10 unmapped read", v, 32'd0);
    rd_reg(8'hA4, v); check("R10 unmapped read A4", v, 32'd0);
    check_state("R10 capture write ignored");

    // R4: zero words disable a span
    for (int i = 8'hA0; i <= 8'hA3; i++) wr_reg(8'(i), 32'd0);
    beat(32'h0000_1000, 5'd7, 4'd3, 1'b1, 1'b1, 2'b00);
    beat(32'h0000_2000, 5'd7, 4'd3, 1'b0, 1'b1, 2'b00);
    check_state("R4 disabled span");

    // configuration A: span0 units 2..5, span1 units 5..7 (overlap at 5)
    wr_reg(8'hA0, (32'd5 << 16) | 32'd2);
    wr_reg(8'hA1, (32'd1 << 24) | (32'd1 << 26) | 32'h0000_000A);
    wr_reg(8'hA2, (32'd7 << 16) | 32'd5);
    wr_reg(8'hA3, (32'd1 << 26) | (32'd1 << 25) | 32'h0000_0001);

    // R3 R4 R5 R6 R7 R9: sweep units, ports, directions with irregular clears
    k = 0;
    for (int u = 0; u < 10; u++) begin
      for (int p = 0; p < 32; p++) begin
        for (int w = 0; w < 2; w++) begin
          k++;
          if (k % 7 == 0) wr_reg(8'hB8, (k % 3 == 0) ? 32'd1 : 32'd3);
          beat((32'(u) << 16) | 32'((p * 977 + w * 13) & 16'hFFFF), 5'(p), 4'((p + u) & 15),
               w[0], 1'b1, 2'b00);
          check_state($sformatf("R3 R4 R7 sweep u=%0d p=%0d w=%0d", u, p, w));
        end
      end
    end

    // R11: valid low changes nothing
    wr_reg(8'hB8, 32'd3);
    beat(32'h0003_0000, 5'd0, 4'd1, 1'b0, 1'b0, 2'b00);
    beat(32'h0003_0000, 5'd0, 4'd1, 1'b1, 1'b0, 2'b00);
    check_state("R11 valid low");

    // R8: writing zero leaves flags, partial clear, same-edge clear plus violation
    beat(32'h0002_0010, 5'd4, 4'd2, 1'b0, 1'b1, 2'b00);
    beat(32'h0004_0020, 5'd30, 4'd9, 1'b1, 1'b1, 2'b00);
    check_state("R8 both set");
    wr_reg(8'hB8, 32'd0);
    check_state("R8 zero write");
    wr_reg(8'hB8, 32'd2);
    check_state("R8 clear write only");
    beat(32'h0006_0040, 5'd2, 4'd5, 1'b0, 1'b1, 2'b01);
    check_state("R8 clear and read violation same edge");
    beat(32'h0005_0080, 5'd2, 4'd6, 1'b0, 1'b1, 2'b00);
    check_state("R7 held after same edge");

    // R4: mode bit alone has no effect, ports 24..31 never allowed
    wr_reg(8'hB8, 32'd3);
    wr_reg(8'hA0, 32'hFFFF_0000);
    wr_reg(8'hA1, (32'd1 << 25) | 32'h00FF_FFFF);
    wr_reg(8'hA2, 32'd0);
    wr_reg(8'hA3, 32'd0);
    beat(32'hFFFF_FFFC, 5'd24, 4'd0, 1'b1, 1'b1, 2'b00);
    check_state("R4 mode bit only");
    wr_reg(8'hA1, (32'd1 << 24) | 32'h00FF_FFFF);
    beat(32'h0000_0000, 5'd23, 4'd1, 1'b1, 1'b1, 2'b00);
    check_state("R4 allowed port 23");
    beat(32'hFFFF_FFFC, 5'd24, 4'd15, 1'b1, 1'b1, 2'b00);
    check_state("R4 port 24 never allowed");

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule